// File: doc/BRIEF.md
# Supervisory reset and watchdog controller

This block turns a digital supply-good indication, a watchdog strobe, two externally driven reset levels and an acknowledge pulse from a companion serial memory into a pair of complementary system resets. All timing runs on a slow tick enable derived from a low-frequency oscillator. The default counts give a watchdog interval of 8000 ticks and a reset stretch of 1000 ticks; at a 5 kHz tick that is 1.6 s and 200 ms.

Any reset event keeps the outputs active for at least the stretch interval. The events are loss of supply, the end of the power-up sequence, a watchdog timeout, or an edge on one of the reset inputs. The watchdog is held at zero whenever the outputs are active. Software can restart the watchdog in two ways: a falling edge on the strobe, or any acknowledge the memory interface returns to the bus master, including one for a dummy command. The reset inputs are edge triggered, so a short external pulse is stretched. If an input is still held when the stretch ends, the outputs stay active until it is released.

Top module: `supv_reset_ctrl`

## Requirements
- R1: `sys_rst_n` is the exact inverse of `sys_rst` at all times, and both show the active state (`sys_rst`=1) while the asynchronous reset is applied.
- R2: While `supply_ok` is 0, the reset outputs are active in the same cycle, with no clock edge needed, and the watchdog count is held at zero.
- R3: After `supply_ok` rises, the outputs stay active for exactly HOLD_TICKS tick enables and are then released.
- R4: While the outputs are inactive and nothing clears the watchdog, the outputs go active on the WD_TICKS-th tick enable.
- R5: A timeout keeps the outputs active for HOLD_TICKS ticks. After release, the watchdog restarts from zero, so the next timeout comes a full WD_TICKS ticks later.
- R6: A high-to-low transition of `wd_strobe` restarts the watchdog count from zero. A low-to-high transition has no effect on the count.
- R7: A one-cycle pulse on `mem_ack` restarts the watchdog count from zero.
- R8: A falling edge on `ext_rst_n` while the outputs are inactive starts a reset period of HOLD_TICKS ticks, even when the input pulse is shorter than that.
- R9: If a reset input is still at its active level (`ext_rst_n`=0 or `ext_rst`=1) when the stretch ends, the outputs stay active until the input returns to idle.
- R10: A rising edge on `ext_rst` while the outputs are inactive starts a reset period of HOLD_TICKS ticks.
- R11: Reset-input edges that arrive while the outputs are already active neither restart nor lengthen the stretch, and they leave no trigger pending after release.
- R12: Counting advances only on cycles with `tick`=1. Strobe and reset inputs are sampled through SYNC_STAGES flops, so they take effect a few clock cycles after they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timing enable from the slow oscillator |
| supply_ok | input | 1 | Supply above trip level, synchronous to clk |
| wd_strobe | input | 1 | Watchdog strobe, asynchronous; a falling edge clears |
| ext_rst_n | input | 1 | External active-low reset level, asynchronous |
| ext_rst | input | 1 | External active-high reset level, asynchronous |
| mem_ack | input | 1 | One-cycle pulse per acknowledge issued by the memory interface |
| sys_rst_n | output | 1 | Active-low system reset |
| sys_rst | output | 1 | Active-high system reset |

## Verification
The hardest situation to reach is a watchdog clear landing on an exact tick position inside the interval. The synchronizer latency has to be accounted for, otherwise an off-by-one in the count goes unnoticed. The bench aligns every stimulus to the cycle just after a tick enable, where the tick period is longer than the input latency. It then sweeps the clear position over every tick of the interval, for both the strobe and the acknowledge path, and expects the remaining run to be exactly a full interval. Reset-input edges are also injected in the middle of a timeout stretch, which shows that the masked edge detector neither extends the stretch nor re-fires afterwards.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [1:0] {
    SV_OFF  = 2'd0,
    SV_HOLD = 2'd1,
    SV_RUN  = 2'd2
  } supv_state_e;

  function automatic int cnt_width(input int n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = din;
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
  end

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= IDLE;
        else        chain_q[g] <= chain_d[g];
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/supv_edge.sv
module supv_edge #(
  parameter logic FALLING = 1'b1,
  parameter logic IDLE    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic mask,
  output logic pulse
);

  logic prev_q;
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= din;
  end

  generate
    if (FALLING) begin : g_fall
      assign seen = prev_q & ~din;
    end else begin : g_rise
      assign seen = ~prev_q & din;
    end
  endgenerate

  assign pulse = seen & ~mask;

endmodule

// File: rtl/supv_tick_cnt.sv
module supv_tick_cnt
  import supv_pkg::*;
#(
  parameter int LIMIT = 8,
  localparam int W    = cnt_width(LIMIT)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt,
  output logic         last
);

  localparam logic [W-1:0] LAST_VAL = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  assign last = (cnt_q == LAST_VAL);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl
  import supv_pkg::*;
#(
  parameter int WD_TICKS    = 8000,
  parameter int HOLD_TICKS  = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic supply_ok,
  input  logic wd_strobe,
  input  logic ext_rst_n,
  input  logic ext_rst,
  input  logic mem_ack,
  output logic sys_rst_n,
  output logic sys_rst
);

  localparam int WD_W   = cnt_width(WD_TICKS);
  localparam int HOLD_W = cnt_width(HOLD_TICKS);

  supv_state_e state_q, state_d;
  logic        hold_fin_q, hold_fin_d;
  logic        in_run, in_hold;
  logic        strobe_s, extn_s, exth_s;
  logic        strobe_fall, extn_fall, exth_rise;
  logic        ext_edge, ext_held;
  logic        wd_clr, wd_last, hold_last;
  logic [WD_W-1:0]   wd_cnt;
  logic [HOLD_W-1:0] hold_cnt;
  logic        rst_act;

  assign in_run  = (state_q == SV_RUN);
  assign in_hold = (state_q == SV_HOLD);

  // input synchronizers
  supv_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync_strobe (
    .clk(clk), .rst_n(rst_n), .din(wd_strobe), .dout(strobe_s));
  supv_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync_extn (
    .clk(clk), .rst_n(rst_n), .din(ext_rst_n), .dout(extn_s));
  supv_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b0)) u_sync_exth (
    .clk(clk), .rst_n(rst_n), .din(ext_rst), .dout(exth_s));

  // edge detectors; reset-input edges are masked while outputs are active
  supv_edge #(.FALLING(1'b1), .IDLE(1'b1)) u_edge_strobe (
    .clk(clk), .rst_n(rst_n), .din(strobe_s), .mask(1'b0), .pulse(strobe_fall));
  supv_edge #(.FALLING(1'b1), .IDLE(1'b1)) u_edge_extn (
    .clk(clk), .rst_n(rst_n), .din(extn_s), .mask(~in_run), .pulse(extn_fall));
  supv_edge #(.FALLING(1'b0), .IDLE(1'b0)) u_edge_exth (
    .clk(clk), .rst_n(rst_n), .din(exth_s), .mask(~in_run), .pulse(exth_rise));

  assign ext_edge = extn_fall | exth_rise;
  assign ext_held = ~extn_s | exth_s;

  // next-state logic
  always_comb begin
    state_d    = state_q;
    hold_fin_d = hold_fin_q;
    case (state_q)
      SV_OFF: begin
        if (supply_ok) begin
          state_d    = SV_HOLD;
          hold_fin_d = 1'b0;
        end
      end
      SV_HOLD: begin
        if (tick && hold_last && !hold_fin_q) hold_fin_d = 1'b1;
        if (hold_fin_d && !ext_held) state_d = SV_RUN;
      end
      SV_RUN: begin
        if (ext_edge || (tick && wd_last)) begin
          state_d    = SV_HOLD;
          hold_fin_d = 1'b0;
        end
      end
      default: state_d = SV_OFF;
    endcase
    if (!supply_ok) begin
      state_d    = SV_OFF;
      hold_fin_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SV_OFF;
      hold_fin_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      hold_fin_q <= hold_fin_d;
    end
  end

  // interval counters
  assign wd_clr = (state_d != SV_RUN) | strobe_fall | mem_ack;

  supv_tick_cnt #(.LIMIT(WD_TICKS)) u_wd_cnt (
    .clk(clk), .rst_n(rst_n), .clr(wd_clr), .en(tick & in_run),
    .cnt(wd_cnt), .last(wd_last));

  supv_tick_cnt #(.LIMIT(HOLD_TICKS)) u_hold_cnt (
    .clk(clk), .rst_n(rst_n), .clr(~in_hold), .en(tick & ~hold_fin_q),
    .cnt(hold_cnt), .last(hold_last));

  // outputs: supply loss acts without waiting for a clock edge
  assign rst_act   = ~supply_ok | ~in_run;
  assign sys_rst   = rst_act;
  assign sys_rst_n = ~rst_act;

endmodule

// File: rtl/supv_reset_chk.sv
module supv_reset_chk
  import supv_pkg::*;
#(
  parameter int WD_TICKS   = 8000,
  parameter int HOLD_TICKS = 1000,
  localparam int WD_W      = cnt_width(WD_TICKS),
  localparam int HOLD_W    = cnt_width(HOLD_TICKS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              supply_ok,
  input logic              mem_ack,
  input logic              sys_rst,
  input logic              sys_rst_n,
  input logic              in_run,
  input logic [WD_W-1:0]   wd_cnt,
  input logic [HOLD_W-1:0] hold_cnt
);

  p_complement_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_n != sys_rst);

  p_supply_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> (sys_rst && !sys_rst_n));

  p_wd_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_run |-> (wd_cnt == '0));

  p_wd_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wd_cnt < WD_W'(WD_TICKS - 1) || wd_cnt == WD_W'(WD_TICKS - 1));

  p_hold_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_cnt < HOLD_W'(HOLD_TICKS - 1) || hold_cnt == HOLD_W'(HOLD_TICKS - 1));

  p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && mem_ack) |=> (wd_cnt == '0));

  p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> supply_ok);

endmodule

bind supv_reset_ctrl supv_reset_chk #(
  .WD_TICKS(WD_TICKS), .HOLD_TICKS(HOLD_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .mem_ack(mem_ack),
  .sys_rst(sys_rst), .sys_rst_n(sys_rst_n), .in_run(in_run),
  .wd_cnt(wd_cnt), .hold_cnt(hold_cnt)
);

// File: tb/sim_supv_reset_ctrl.sv
`timescale 1ns/1ps
module sim_supv_reset_ctrl;

  localparam int WD   = 12;
  localparam int HOLD = 5;
  localparam int TDIV = 8;

  logic clk, rst_n, tick, supply_ok, wd_strobe, ext_rst_n, ext_rst, mem_ack;
  logic sys_rst_n, sys_rst;
  int   total, bad, ph;
  bit   done;

  supv_reset_ctrl #(.WD_TICKS(WD), .HOLD_TICKS(HOLD), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
    .wd_strobe(wd_strobe), .ext_rst_n(ext_rst_n), .ext_rst(ext_rst),
    .mem_ack(mem_ack), .sys_rst_n(sys_rst_n), .sys_rst(sys_rst));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // tick enable: one cycle in TDIV, updated 1 ns after the edge
  initial begin
    tick = 1'b0;
    ph   = 0;
    forever begin
      @(posedge clk);
      #1;
      ph   = (ph == TDIV - 1) ? 0 : ph + 1;
      tick = (ph == TDIV - 1);
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // move to the cycle just after an edge that consumed a tick
  task automatic sync_tick();
    int g = 0;
    while (!tick && g < 100) begin step(); g++; end
    step();
  endtask

  // count ticks consumed while sys_rst stays at lvl
  task automatic measure(input logic lvl, output int n);
    int g = 0;
    n = 0;
    while (sys_rst == lvl && g < 4000) begin
      if (tick) n++;
      step();
      g++;
    end
  endtask

  task automatic count_ticks(input int k);
    int n = 0;
    int g = 0;
    while (n < k && g < 4000) begin
      if (tick) n++;
      step();
      g++;
    end
  endtask

  task automatic wait_level(input logic lvl);
    int g = 0;
    while (sys_rst != lvl && g < 100) begin step(); g++; end
  endtask

  initial begin
    done = 0;
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    total = 0; bad = 0;
    rst_n = 1'b0; supply_ok = 1'b0; wd_strobe = 1'b1;
    ext_rst_n = 1'b1; ext_rst = 1'b0; mem_ack = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk("R1 sys_rst in reset", sys_rst, 1);
    chk("R1 sys_rst_n in reset", sys_rst_n, 0);
    rst_n = 1'b1;
    step(); step();
    chk("R2 supply low holds reset", sys_rst, 1);

    // R3 power-up stretch
    sync_tick();
    supply_ok = 1'b1;
    measure(1'b1, n);
    chk("R3 power-up stretch ticks", n, HOLD);
    chk("R1 released complement", sys_rst_n, 1);

    // R4 timeout, R5 stretch and restart
    measure(1'b0, n);
    chk("R4 watchdog interval", n, WD);
    measure(1'b1, n);
    chk("R5 timeout stretch", n, HOLD);
    measure(1'b0, n);
    chk("R5 restart full interval", n, WD);
    measure(1'b1, n);

    // R6 strobe falling edge sweep
    for (int k = 1; k < WD; k++) begin
      count_ticks(k);
      wd_strobe = 1'b0;
      measure(1'b0, n);
      chk($sformatf("R6 strobe clear at %0d", k), n, WD);
      wd_strobe = 1'b1;
      measure(1'b1, n);
      chk("R5 stretch after strobe run", n, HOLD);
    end

    // R6 rising edge has no effect
    wd_strobe = 1'b0;
    measure(1'b1, n);
    count_ticks(3);
    wd_strobe = 1'b1;
    measure(1'b0, n);
    chk("R6 rising strobe ignored", n, WD - 3);
    measure(1'b1, n);

    // R7 acknowledge sweep
    for (int k = 1; k < WD; k++) begin
      count_ticks(k);
      mem_ack = 1'b1;
      step();
      mem_ack = 1'b0;
      measure(1'b0, n);
      chk($sformatf("R7 ack clear at %0d", k), n, WD);
      measure(1'b1, n);
    end

    // R8 short active-low pulse stretched; R12 sync latency below a tick period
    count_ticks(2);
    ext_rst_n = 1'b0;
    step(); step(); step();
    ext_rst_n = 1'b1;
    wait_level(1'b1);
    measure(1'b1, n);
    chk("R8 short low pulse stretch", n, HOLD);
    measure(1'b0, n);
    chk("R5 wd cleared during input stretch", n, WD);
    measure(1'b1, n);

    // R9 held longer than stretch
    for (int extra = 1; extra <= 3; extra++) begin
      count_ticks(1);
      ext_rst_n = 1'b0;
      wait_level(1'b1);
      count_ticks(HOLD + extra);
      ext_rst_n = 1'b1;
      measure(1'b1, n);
      chk($sformatf("R9 held low extra %0d", extra), n, 0);
      measure(1'b0, n);
      measure(1'b1, n);
    end

    // R10 active-high pulse, then held
    count_ticks(4);
    ext_rst = 1'b1;
    step(); step(); step();
    ext_rst = 1'b0;
    wait_level(1'b1);
    measure(1'b1, n);
    chk("R10 short high pulse stretch", n, HOLD);
    count_ticks(1);
    ext_rst = 1'b1;
    wait_level(1'b1);
    count_ticks(HOLD + 2);
    ext_rst = 1'b0;
    measure(1'b1, n);
    chk("R9 held high beyond stretch", n, 0);
    measure(1'b0, n);
    chk("R10 interval after release", n, WD);

    // R11 edges during an active stretch are ignored
    ext_rst_n = 1'b0;
    ext_rst   = 1'b1;
    step(); step(); step();
    ext_rst_n = 1'b1;
    ext_rst   = 1'b0;
    measure(1'b1, n);
    chk("R11 no extension from masked edges", n, HOLD);
    measure(1'b0, n);
    chk("R11 no retrigger after release", n, WD);
    measure(1'b1, n);

    // R2 immediate assertion on supply loss, then R3 again
    count_ticks(4);
    chk("R2 running before drop", sys_rst, 0);
    supply_ok = 1'b0;
    #1;
    chk("R2 immediate reset on drop", sys_rst, 1);
    chk("R1 complement on drop", sys_rst_n, 0);
    repeat (20) step();
    chk("R2 held while supply low", sys_rst, 1);
    sync_tick();
    supply_ok = 1'b1;
    measure(1'b1, n);
    chk("R3 stretch after supply return", n, HOLD);
    measure(1'b0, n);
    chk("R12 full interval after return", n, WD);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule